// File: doc/BRIEF.md
# Multiplexed-Address DRAM Device Model

This block is a synthesizable, clocked model of the control side of an asynchronous, one-bit-wide dynamic memory. The row and column address share a single address bus. A memory controller under test drives the active-low row strobe, column strobe and write enable, the address and the write data. The model samples those pins on its own clock and answers the way such a device would. It returns read data on a data output that has an enable, so that a tri-state pad can be built from it. It also reports every row refresh it performs on a strobe with a row number.

The cell array is a small parameterised register file, addressed by the low bits of the latched row and column, rather than a full megabit. The access time from the column strobe is a parameterised number of clock cycles. All pins are taken as synchronous to the model clock. A pin "falls" at the first rising clock edge that samples it low after it was sampled high. The following cycle types are recognised:

- read
- early write (write enable already low when the column strobe falls)
- delayed write and read-modify-write (write enable falls while the column strobe is low)
- column-before-row refresh, which uses an internal row counter
- hidden refresh
- row-only refresh

Top module: `mux_dram_core`

## Requirements
- R1: At a row-strobe fall with the column strobe sampled high, the row is taken from `addr`. At the next column-strobe fall while the row is open, the column is taken from the same `addr` pins. The cell used is {row[ROW_BITS-1:0], column[COL_BITS-1:0]}.
- R2: A column-strobe fall with `we_n` high starts a read. In a read, `din` has no effect on the array.
- R3: `q_oe` stays low until the edge ACC_CYC cycles after the edge that saw the column strobe fall. It then stays high while `cas_n` stays low. It goes low at the first edge that samples `cas_n` high.
- R4: A column-strobe fall with `we_n` already low is an early write. `din` is stored at that edge, and `q_oe` stays low for the whole cycle.
- R5: A `we_n` fall during an open read, with the column strobe low, is a delayed write. `din` is stored at that edge. `q` then shows the data that the cell held before the write, with the read timing of R3.
- R6: Data read from a cell has the same polarity as the data last written to it.
- R7: A row-strobe fall with `cas_n` already low is a refresh from the internal counter. `rfsh_stb` pulses for one cycle with `rfsh_row` equal to the counter, `addr` is ignored, and the counter then advances by one, wrapping from 511 to 0.
- R8: A hidden refresh holds `cas_n` low after a read while the row strobe is cycled. It is handled as in R7, and `q_oe` and `q` keep the read data.
- R9: A row-strobe fall with `cas_n` high pulses `rfsh_stb` with `rfsh_row` = addr[8:0]. If the column strobe then stays high, `q_oe` stays low.
- R10: While `rst_n` is low, `q_oe` and `rfsh_stb` are low and the refresh counter returns to 0. The array contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, low selects write |
| addr | input | ADDR_W (10) | Shared row/column address |
| din | input | 1 | Write data |
| q | output | 1 | Read data |
| q_oe | output | 1 | Output enable for `q`; low means high impedance |
| rfsh_stb | output | 1 | One-cycle pulse per refreshed row |
| rfsh_row | output | RF_W (9) | Row refreshed with the current pulse |

## Verification
The assertions rely on the controller pins being synchronous to `clk`. They also assume the row and column strobes never fall in the same cycle, every strobe level is held for at least one cycle, and ACC_CYC is at least 1. The stimulus meets this by changing pins only on falling clock edges and moving one strobe per half-period step. It also leaves a precharge cycle with both strobes high between cycles, except where a hidden refresh keeps the column strobe low on purpose.

// File: rtl/mux_dram_pkg.sv
package mux_dram_pkg;
  // Kind of column cycle currently in progress
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_EARLY = 2'd2,
    CYC_LATE  = 2'd3
  } cyc_e;
endpackage

// File: rtl/mux_dram_pin_sampler.sv
module mux_dram_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic ras_fall,
  output logic ras_rise,
  output logic cas_fall,
  output logic cas_rise,
  output logic we_fall
);
  logic ras_p_q, cas_p_q, we_p_q;

  // previous-sample registers, idle (high) after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_p_q <= 1'b1;
      cas_p_q <= 1'b1;
      we_p_q  <= 1'b1;
    end else begin
      ras_p_q <= ras_n;
      cas_p_q <= cas_n;
      we_p_q  <= we_n;
    end
  end

  always_comb begin
    ras_fall = ras_p_q & ~ras_n;
    ras_rise = ~ras_p_q & ras_n;
    cas_fall = cas_p_q & ~cas_n;
    cas_rise = ~cas_p_q & cas_n;
    we_fall  = we_p_q & ~we_n;
  end
endmodule

// File: rtl/mux_dram_refresh_ctr.sv
module mux_dram_refresh_ctr #(
  parameter int RF_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  output logic [RF_W-1:0] count
);
  logic [RF_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc) cnt_d = cnt_q + 1'b1;  // natural wrap at 2**RF_W
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (inc) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/mux_dram_cell_array.sv
module mux_dram_cell_array #(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [ROW_BITS+COL_BITS-1:0] wr_idx,
  input  logic                         wr_bit,
  input  logic [ROW_BITS+COL_BITS-1:0] rd_idx,
  output logic                         rd_bit
);
  localparam int IDX_W = ROW_BITS + COL_BITS;
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] cells;

  // storage cells carry no reset, like the array they stand in for
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic bit_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(i))) bit_q <= wr_bit;
    end
    assign cells[i] = bit_q;
  end

  assign rd_bit = cells[rd_idx];
endmodule

// File: rtl/mux_dram_cycle_ctrl.sv
module mux_dram_cycle_ctrl
  import mux_dram_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int RF_W     = 9,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int ACC_CYC  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cas_n,
  input  logic                         we_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         din,
  input  logic                         ras_fall,
  input  logic                         ras_rise,
  input  logic                         cas_fall,
  input  logic                         cas_rise,
  input  logic                         we_fall,
  input  logic [RF_W-1:0]              rf_count,
  input  logic                         rd_bit,
  output logic                         rf_inc,
  output logic                         wr_en,
  output logic [ROW_BITS+COL_BITS-1:0] wr_idx,
  output logic                         wr_bit,
  output logic [ROW_BITS+COL_BITS-1:0] rd_idx,
  output logic                         q,
  output logic                         q_oe,
  output logic                         rfsh_stb,
  output logic [RF_W-1:0]              rfsh_row
);
  localparam int CNT_W = (ACC_CYC < 2) ? 1 : $clog2(ACC_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_CYC - 1);

  logic [ROW_BITS-1:0] row_q, row_d;
  logic [COL_BITS-1:0] col_q, col_d;
  logic                open_q, open_d;
  cyc_e                cyc_q, cyc_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                pend_q, pend_d;
  logic                q_q, q_d;
  logic                oe_q, oe_d;
  logic                stb_q, stb_d;
  logic [RF_W-1:0]     srow_q, srow_d;
  logic                unused_addr_hi;

  assign unused_addr_hi = ^addr[ADDR_W-1:RF_W];

  // read index always points at the column on the pins: used only at a column fall
  assign rd_idx = {row_q, addr[COL_BITS-1:0]};

  always_comb begin
    row_d  = row_q;
    col_d  = col_q;
    open_d = open_q;
    cyc_d  = cyc_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    q_d    = q_q;
    oe_d   = oe_q;
    stb_d  = 1'b0;
    srow_d = srow_q;
    rf_inc = 1'b0;
    wr_en  = 1'b0;
    wr_idx = {row_q, col_q};
    wr_bit = din;

    // row strobe: refresh bookkeeping and row latch
    if (ras_fall) begin
      stb_d = 1'b1;
      if (!cas_n) begin
        // column strobe already low: counter-driven refresh, pins ignored
        srow_d = rf_count;
        rf_inc = 1'b1;
        open_d = 1'b0;
      end else begin
        srow_d = addr[RF_W-1:0];
        row_d  = addr[ROW_BITS-1:0];
        open_d = 1'b1;
      end
    end else if (ras_rise) begin
      open_d = 1'b0;
    end

    // access delay countdown
    if (pend_q) begin
      if (cnt_q == '0) begin
        oe_d   = 1'b1;
        pend_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end

    // column strobe and write enable
    if (cas_rise) begin
      cyc_d  = CYC_IDLE;
      oe_d   = 1'b0;
      pend_d = 1'b0;
    end else if (cas_fall && open_q) begin
      col_d = addr[COL_BITS-1:0];
      if (!we_n) begin
        cyc_d  = CYC_EARLY;
        wr_en  = 1'b1;
        wr_idx = {row_q, addr[COL_BITS-1:0]};
      end else begin
        cyc_d  = CYC_READ;
        q_d    = rd_bit;
        pend_d = 1'b1;
        cnt_d  = CNT_LOAD;
      end
    end else if (we_fall && !cas_n && open_q && (cyc_q == CYC_READ)) begin
      cyc_d = CYC_LATE;
      wr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      open_q <= 1'b0;
      cyc_q  <= CYC_IDLE;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      q_q    <= 1'b0;
      oe_q   <= 1'b0;
      stb_q  <= 1'b0;
      srow_q <= '0;
    end else begin
      row_q  <= row_d;
      col_q  <= col_d;
      open_q <= open_d;
      cyc_q  <= cyc_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      q_q    <= q_d;
      oe_q   <= oe_d;
      stb_q  <= stb_d;
      srow_q <= srow_d;
    end
  end

  assign q        = q_q;
  assign q_oe     = oe_q;
  assign rfsh_stb = stb_q;
  assign rfsh_row = srow_q;
endmodule

// File: rtl/mux_dram_core.sv
module mux_dram_core #(
  parameter int ADDR_W   = 10,
  parameter int RF_W     = 9,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3,
  parameter int ACC_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              q,
  output logic              q_oe,
  output logic              rfsh_stb,
  output logic [RF_W-1:0]   rfsh_row
);
  localparam int IDX_W = ROW_BITS + COL_BITS;

  logic             ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic [RF_W-1:0]  rf_count;
  logic             rf_inc;
  logic             wr_en, wr_bit, rd_bit;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  mux_dram_pin_sampler u_smp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ras_fall (ras_fall),
    .ras_rise (ras_rise),
    .cas_fall (cas_fall),
    .cas_rise (cas_rise),
    .we_fall  (we_fall)
  );

  mux_dram_refresh_ctr #(.RF_W(RF_W)) u_rfc (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (rf_inc),
    .count (rf_count)
  );

  mux_dram_cell_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_arr (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_bit (wr_bit),
    .rd_idx (rd_idx),
    .rd_bit (rd_bit)
  );

  mux_dram_cycle_ctrl #(
    .ADDR_W   (ADDR_W),
    .RF_W     (RF_W),
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .ACC_CYC  (ACC_CYC)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .addr     (addr),
    .din      (din),
    .ras_fall (ras_fall),
    .ras_rise (ras_rise),
    .cas_fall (cas_fall),
    .cas_rise (cas_rise),
    .we_fall  (we_fall),
    .rf_count (rf_count),
    .rd_bit   (rd_bit),
    .rf_inc   (rf_inc),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_bit   (wr_bit),
    .rd_idx   (rd_idx),
    .q        (q),
    .q_oe     (q_oe),
    .rfsh_stb (rfsh_stb),
    .rfsh_row (rfsh_row)
  );
endmodule

// File: rtl/mux_dram_core_chk.sv
module mux_dram_core_chk #(
  parameter int ADDR_W = 10,
  parameter int RF_W   = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              q,
  input logic              q_oe,
  input logic              rfsh_stb,
  input logic [RF_W-1:0]   rfsh_row
);
  logic            ras_p, cas_p, ew_act, cbr_d, have_prev;
  logic [RF_W-1:0] prev_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_p     <= 1'b1;
      cas_p     <= 1'b1;
      ew_act    <= 1'b0;
      cbr_d     <= 1'b0;
      have_prev <= 1'b0;
      prev_row  <= '0;
    end else begin
      ras_p <= ras_n;
      cas_p <= cas_n;
      if (cas_p && !cas_n && !we_n && !ras_n) ew_act <= 1'b1;
      else if (cas_n)                          ew_act <= 1'b0;
      cbr_d <= ras_p && !ras_n && !cas_n;
      if (cbr_d) begin
        have_prev <= 1'b1;
        prev_row  <= rfsh_row;
      end
    end
  end

  AST_Q_ONLY_CAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_oe |-> !$past(cas_n)); // R3

  AST_Q_HELD_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (q_oe && $past(q_oe)) |-> $stable(q)); // R8

  AST_EARLY_WR_NO_Q: assert property (@(posedge clk) disable iff (!rst_n)
    ew_act |-> !q_oe); // R4

  AST_RAS_FALL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |=> rfsh_stb); // R7

  AST_EXT_ROW_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && cas_n) |=> (rfsh_row == $past(addr[RF_W-1:0]))); // R9

  AST_CTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cbr_d && have_prev) |-> (rfsh_row == RF_W'(prev_row + 1'b1))); // R7

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_stb |=> !rfsh_stb); // R7
endmodule

bind mux_dram_core mux_dram_core_chk #(.ADDR_W(ADDR_W), .RF_W(RF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .we_n     (we_n),
  .addr     (addr),
  .q        (q),
  .q_oe     (q_oe),
  .rfsh_stb (rfsh_stb),
  .rfsh_row (rfsh_row)
);

// File: tb/mux_dram_core_tb.sv
module mux_dram_core_tb;
  localparam int ACC = 2;
  localparam logic [1:0] OP_EW = 2'd0, OP_LW = 2'd1, OP_RD = 2'd2, OP_RMW = 2'd3;
  localparam int NV = 13;
  // {op, row, col, data, expected}
  localparam logic [23:0] VEC [NV] = '{
    {OP_EW,  10'd5,   10'd3,   1'b1, 1'b0},
    {OP_EW,  10'd2,   10'd7,   1'b0, 1'b0},
    {OP_RD,  10'd5,   10'd3,   1'b0, 1'b1},
    {OP_RD,  10'd2,   10'd7,   1'b0, 1'b0},
    {OP_LW,  10'h105, 10'h203, 1'b0, 1'b0},
    {OP_RD,  10'd5,   10'd3,   1'b0, 1'b0},
    {OP_RMW, 10'd2,   10'd7,   1'b1, 1'b0},
    {OP_RD,  10'd2,   10'd7,   1'b0, 1'b1},
    {OP_EW,  10'd1,   10'd1,   1'b1, 1'b0},
    {OP_RD,  10'd5,   10'd3,   1'b0, 1'b0},
    {OP_RD,  10'd1,   10'd1,   1'b0, 1'b1},
    {OP_RMW, 10'd1,   10'd1,   1'b0, 1'b1},
    {OP_RD,  10'd1,   10'd1,   1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n, ras_n, cas_n, we_n, din;
  logic [9:0] addr;
  logic       q, q_oe, rfsh_stb;
  logic [8:0] rfsh_row;
  int         checks = 0;
  int         errors = 0;
  logic [8:0] exp_ctr;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  mux_dram_core #(.ACC_CYC(ACC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .q(q), .q_oe(q_oe),
    .rfsh_stb(rfsh_stb), .rfsh_row(rfsh_row)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic open_row(input logic [9:0] row);
    addr = row; ras_n = 1'b0;
    @(negedge clk);
    chk("R9 strobe", 16'(rfsh_stb), 16'd1);
    chk("R9 row", 16'(rfsh_row), 16'(row[8:0]));
  endtask

  task automatic close_all();
    cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    chk("R3 off after cas rise", 16'(q_oe), 16'd0);
    @(negedge clk);
  endtask

  task automatic do_op(input logic [1:0] op, input logic [9:0] row, input logic [9:0] col,
                       input logic d, input logic expv);
    open_row(row);
    addr = col;
    we_n = (op == OP_EW) ? 1'b0 : 1'b1;
    din  = (op == OP_RD) ? ~expv : d;  // R2: opposite data on a read must not land
    cas_n = 1'b0;
    @(negedge clk);
    if (op == OP_EW) begin
      repeat (ACC + 1) begin
        chk("R4 early write keeps q off", 16'(q_oe), 16'd0);
        @(negedge clk);
      end
    end else begin
      if (op != OP_RD) we_n = 1'b0;  // R5 delayed write strobe
      repeat (ACC - 1) @(negedge clk);
      chk("R3 q off before access delay", 16'(q_oe), 16'd0);
      @(negedge clk);
      chk("R3 q on after access delay", 16'(q_oe), 16'd1);
      if (op != OP_LW) chk("R6/R5 read data", 16'(q), 16'(expv));
      @(negedge clk);
      chk("R3 q held while cas low", 16'(q_oe), 16'd1);
    end
    close_all();
  endtask

  task automatic cbr(input logic [9:0] junk);
    cas_n = 1'b0;
    @(negedge clk);
    addr = junk; ras_n = 1'b0;
    @(negedge clk);
    chk("R7 strobe", 16'(rfsh_stb), 16'd1);
    chk("R7 counter row", 16'(rfsh_row), 16'(exp_ctr));
    chk("R7 no output", 16'(q_oe), 16'd0);
    exp_ctr = exp_ctr + 1'b1;
    ras_n = 1'b1; cas_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; din = 1'b0; addr = '0;
    exp_ctr = '0;
    repeat (3) @(negedge clk);
    chk("R10 q_oe in reset", 16'(q_oe), 16'd0);
    chk("R10 stb in reset", 16'(rfsh_stb), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R4 R5 R6: table walk (aliasing upper address bits in entry 4)
    for (int i = 0; i < NV; i++)
      do_op(VEC[i][23:22], VEC[i][21:12], VEC[i][11:2], VEC[i][1], VEC[i][0]);

    // R9: row-only refresh with column strobe high
    addr = 10'h1A5; ras_n = 1'b0;
    @(negedge clk);
    chk("R9 row-only strobe", 16'(rfsh_stb), 16'd1);
    chk("R9 row-only row", 16'(rfsh_row), 16'h1A5);
    @(negedge clk);
    chk("R9 strobe is a pulse", 16'(rfsh_stb), 16'd0);
    chk("R9 q stays off", 16'(q_oe), 16'd0);
    ras_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    // R7: counter refresh ignores the pins and wraps
    for (int i = 0; i < 514; i++) cbr(10'(3 * i + 7));

    // R8: hidden refresh after reading cell (2,7) = 1
    open_row(10'd2);
    addr = 10'd7; cas_n = 1'b0;
    repeat (ACC + 1) @(negedge clk);
    chk("R8 read before hidden", 16'(q), 16'd1);
    ras_n = 1'b1;
    @(negedge clk);
    addr = 10'h3FF; ras_n = 1'b0;
    @(negedge clk);
    chk("R8 hidden strobe", 16'(rfsh_stb), 16'd1);
    chk("R8 hidden counter row", 16'(rfsh_row), 16'(exp_ctr));
    exp_ctr = exp_ctr + 1'b1;
    @(negedge clk);
    chk("R8 q_oe kept", 16'(q_oe), 16'd1);
    chk("R8 q kept", 16'(q), 16'd1);
    close_all();

    // R10: reset mid-run clears counter but not the array
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 q_oe after reset", 16'(q_oe), 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    exp_ctr = '0;
    cbr(10'h2AA);
    do_op(OP_RD, 10'd2, 10'd7, 1'b0, 1'b1);  // R10 array retained

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule